// File: doc/BRIEF.md
# Five-Stage Decimate-by-18 CIC Filter with Coarse Gain

This block lowers the sample rate of a complex baseband stream by a factor of eighteen, for example from 72 MSPS to 4 MSPS. It uses a cascaded integrator-comb structure with no multipliers in the filter path. Five running-sum integrators work at the input rate, and five first-difference combs with unit delay work at the decimated rate, so the filter has linear phase. The I and Q rails go through identical, independent datapaths and share one valid pipeline and one decimation phase counter.

The filter's DC gain is 18^5, which is about 1.89e6. That is not a power of two, so a trailing gain stage scales the result in two steps. It first drops a fixed number of low bits, then multiplies by a programmable unsigned fixed-point coefficient. The product is then truncated and clipped to the 16-bit output. The filter accepts a sample whenever `in_valid` is high, and it ignores the data pins in any cycle where `in_valid` is low.

Top module: `cic5_decimator`

## Requirements
- R1: While `rst` is high and in the cycle after it, `out_valid` is low. After reset, `out_i` and `out_q` read zero until the first output.
- R2: Exactly one output is produced for every 18 accepted input samples. The first output follows the 18th accepted sample after reset, and no output follows only 17.
- R3: Before scaling, output m equals the five-fold convolution of an 18-sample all-ones window with the input. It is evaluated at accepted sample 18m+17 (counting from 0), and samples before reset count as zero. For constant input x in steady state, this value is x·18^5.
- R4: The scaling arithmetic-shifts the filter value right by 20 bits (floor) and multiplies the result by `gain_coef`. `gain_coef` is an unsigned 18-bit value with 16 fraction bits, so 65536 means 1.0. The product is then arithmetic-shifted right by 16 bits (floor). A coefficient of 0 gives zero outputs.
- R5: A scaled value above 32767 is output as 32767, and one below -32768 is output as -32768.
- R6: The sample value on `in_i`/`in_q` in a cycle with `in_valid` low has no effect on any output value and is not counted toward the decimation ratio.
- R7: The I and Q rails are filtered independently. Each output rail depends only on its own input rail.
- R8: The integrators wrap modulo 2^37. Outputs stay exact over long runs of full-scale input, because the comb differences undo the wrap.
- R9: `out_valid` is a one-cycle pulse. `out_i` and `out_q` change only in a cycle where `out_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample qualifier |
| in_i | input | 16 | In-phase input sample, two's complement |
| in_q | input | 16 | Quadrature input sample, two's complement |
| gain_coef | input | 18 | Unsigned gain multiplier, 16 fraction bits |
| out_valid | output | 1 | One-cycle pulse marking a new output |
| out_i | output | 16 | In-phase decimated output |
| out_q | output | 16 | Quadrature decimated output |

## Verification
The assertions assume that `gain_coef` stays constant from the decimating sample until its output appears. The bench changes the coefficient only after the pipeline has drained, with at least twenty idle cycles after the last input. The assertions also assume that `rst` is held for several cycles at start-up, so every register has a known value before the checks are enabled. The stimulus drives garbage on the data pins during idle cycles, so the ignore rule is tested. Long full-scale runs push the integrators past their wrap point.

// File: rtl/cic5_pkg.sv
package cic5_pkg;

  localparam int DEF_IN_W      = 16;
  localparam int DEF_STAGES    = 5;
  localparam int DEF_RATIO     = 18;
  localparam int DEF_SHIFT     = 20;
  localparam int DEF_COEF_W    = 18;
  localparam int DEF_COEF_FRAC = 16;
  localparam int DEF_OUT_W     = 16;

  // Bits of growth needed to hold ratio^stages without overflow.
  function automatic int growth_bits(input int ratio, input int stages);
    longint g;
    g = 1;
    for (int s = 0; s < stages; s++) g = g * ratio;
    return $clog2(g);
  endfunction

endpackage

// File: rtl/cic5_integrators.sv
module cic5_integrators #(
  parameter int IN_W   = 16,
  parameter int ACC_W  = 37,
  parameter int STAGES = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [STAGES-1:0]       en,
  input  logic signed [IN_W-1:0]  din,
  output logic signed [ACC_W-1:0] dout
);

  // Each stage fires one clock after its predecessor, so a sample ripples
  // through one adder per cycle while the cascade stays exact.
  for (genvar s = 0; s < STAGES; s++) begin : g_st
    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] feed;
    if (s == 0) begin : g_first
      assign feed = ACC_W'(din);
    end else begin : g_next
      assign feed = g_st[s-1].acc;
    end
    always_ff @(posedge clk) begin
      if (rst)        acc <= '0;
      else if (en[s]) acc <= acc + feed;   // wraps modulo 2^ACC_W
    end
  end

  assign dout = g_st[STAGES-1].acc;

endmodule

// File: rtl/cic5_phase.sv
module cic5_phase #(
  parameter int RATIO = 18
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output logic take
);

  localparam int CNT_W = (RATIO > 2) ? $clog2(RATIO) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RATIO - 1);

  logic [CNT_W-1:0] cnt;

  assign take = tick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

endmodule

// File: rtl/cic5_combs.sv
module cic5_combs #(
  parameter int ACC_W  = 37,
  parameter int STAGES = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [STAGES-1:0]       en,
  input  logic signed [ACC_W-1:0] din,
  output logic signed [ACC_W-1:0] dout
);

  // Differential delay of one decimated sample per stage.
  for (genvar s = 0; s < STAGES; s++) begin : g_st
    logic signed [ACC_W-1:0] src;
    logic signed [ACC_W-1:0] prev;
    logic signed [ACC_W-1:0] diff;
    if (s == 0) begin : g_first
      assign src = din;
    end else begin : g_next
      assign src = g_st[s-1].diff;
    end
    always_ff @(posedge clk) begin
      if (rst) begin
        prev <= '0;
        diff <= '0;
      end else if (en[s]) begin
        diff <= src - prev;
        prev <= src;
      end
    end
  end

  assign dout = g_st[STAGES-1].diff;

endmodule

// File: rtl/cic5_gain.sv
module cic5_gain #(
  parameter int ACC_W     = 37,
  parameter int SHIFT     = 20,
  parameter int COEF_W    = 18,
  parameter int COEF_FRAC = 16,
  parameter int OUT_W     = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [1:0]              en,
  input  logic signed [ACC_W-1:0] din,
  input  logic [COEF_W-1:0]       coef,
  output logic signed [OUT_W-1:0] dout
);

  localparam int KEEP_W = ACC_W - SHIFT;
  localparam int PROD_W = KEEP_W + COEF_W + 1;
  localparam int SCL_W  = PROD_W - COEF_FRAC;
  localparam logic signed [OUT_W-1:0] POS_MAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic signed [OUT_W-1:0] NEG_MAX = {1'b1, {(OUT_W-1){1'b0}}};

  logic signed [KEEP_W-1:0]  kept;
  logic signed [COEF_W:0]    coef_s;
  logic signed [PROD_W-1:0]  prod_q;
  logic signed [SCL_W-1:0]   scaled;
  logic [SCL_W-OUT_W:0]      head;
  logic signed [OUT_W-1:0]   clipped;

  assign kept   = KEEP_W'(din >>> SHIFT);
  assign coef_s = {1'b0, coef};

  // Stage A: coarse shift already applied, fine multiply registered.
  always_ff @(posedge clk) begin
    if (rst)        prod_q <= '0;
    else if (en[0]) prod_q <= PROD_W'(kept) * PROD_W'(coef_s);
  end

  assign scaled = SCL_W'(prod_q >>> COEF_FRAC);
  assign head   = scaled[SCL_W-1:OUT_W-1];

  always_comb begin
    if ((&head) || !(|head)) clipped = {scaled[OUT_W-1], scaled[OUT_W-2:0]};
    else if (head[SCL_W-OUT_W])  clipped = NEG_MAX;
    else                         clipped = POS_MAX;
  end

  // Stage B: clipped result registered straight onto the output.
  always_ff @(posedge clk) begin
    if (rst)        dout <= '0;
    else if (en[1]) dout <= clipped;
  end

endmodule

// File: rtl/cic5_decimator.sv
module cic5_decimator #(
  parameter int IN_W      = cic5_pkg::DEF_IN_W,
  parameter int STAGES    = cic5_pkg::DEF_STAGES,
  parameter int RATIO     = cic5_pkg::DEF_RATIO,
  parameter int SHIFT     = cic5_pkg::DEF_SHIFT,
  parameter int COEF_W    = cic5_pkg::DEF_COEF_W,
  parameter int COEF_FRAC = cic5_pkg::DEF_COEF_FRAC,
  parameter int OUT_W     = cic5_pkg::DEF_OUT_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [IN_W-1:0]   in_i,
  input  logic signed [IN_W-1:0]   in_q,
  input  logic [COEF_W-1:0]        gain_coef,
  output logic                     out_valid,
  output logic signed [OUT_W-1:0]  out_i,
  output logic signed [OUT_W-1:0]  out_q
);

  localparam int GROWTH = cic5_pkg::growth_bits(RATIO, STAGES);
  localparam int ACC_W  = IN_W + GROWTH;
  localparam int NCH    = 2;

  // Shared qualifier pipelines: one bit per integrator / comb stage.
  logic [STAGES-1:0] int_q;
  logic [STAGES-1:0] cmb_q;
  logic              gain_q;
  logic [STAGES-1:0] int_en;
  logic [STAGES-1:0] cmb_en;
  logic              take;

  assign int_en = {int_q[STAGES-2:0], in_valid};
  assign cmb_en = {cmb_q[STAGES-2:0], take};

  always_ff @(posedge clk) begin
    if (rst) begin
      int_q     <= '0;
      cmb_q     <= '0;
      gain_q    <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      int_q     <= int_en;
      cmb_q     <= cmb_en;
      gain_q    <= cmb_q[STAGES-1];
      out_valid <= gain_q;
    end
  end

  cic5_phase #(.RATIO(RATIO)) u_phase (
    .clk  (clk),
    .rst  (rst),
    .tick (int_q[STAGES-1]),
    .take (take)
  );

  logic signed [IN_W-1:0]  ch_in  [NCH];
  logic signed [OUT_W-1:0] ch_out [NCH];

  assign ch_in[0] = in_i;
  assign ch_in[1] = in_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic signed [ACC_W-1:0] integ;
    logic signed [ACC_W-1:0] comb;

    cic5_integrators #(.IN_W(IN_W), .ACC_W(ACC_W), .STAGES(STAGES)) u_int (
      .clk  (clk),
      .rst  (rst),
      .en   (int_en),
      .din  (ch_in[c]),
      .dout (integ)
    );

    cic5_combs #(.ACC_W(ACC_W), .STAGES(STAGES)) u_comb (
      .clk  (clk),
      .rst  (rst),
      .en   (cmb_en),
      .din  (integ),
      .dout (comb)
    );

    cic5_gain #(
      .ACC_W(ACC_W), .SHIFT(SHIFT), .COEF_W(COEF_W),
      .COEF_FRAC(COEF_FRAC), .OUT_W(OUT_W)
    ) u_gain (
      .clk  (clk),
      .rst  (rst),
      .en   ({gain_q, cmb_q[STAGES-1]}),
      .din  (comb),
      .coef (gain_coef),
      .dout (ch_out[c])
    );
  end

  assign out_i = ch_out[0];
  assign out_q = ch_out[1];

endmodule

// File: rtl/cic5_decimator_chk.sv
module cic5_decimator_chk #(
  parameter int RATIO  = 18,
  parameter int COEF_W = 18,
  parameter int OUT_W  = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic [COEF_W-1:0]       gain_coef,
  input logic                    out_valid,
  input logic signed [OUT_W-1:0] out_i,
  input logic signed [OUT_W-1:0] out_q
);

  logic [31:0] seen_in;
  logic [31:0] seen_out;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_in  <= '0;
      seen_out <= '0;
    end else begin
      if (in_valid)  seen_in  <= seen_in + 32'd1;
      if (out_valid) seen_out <= seen_out + 32'd1;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !out_valid);

  // R2
  ratio_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((seen_out + 32'd1) * 32'(RATIO) <= seen_in));

  // R9
  pulse_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(out_i) || !$stable(out_q)) |-> out_valid);

  // R4
  zero_gain_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && gain_coef == '0) |-> (out_i == '0 && out_q == '0));

endmodule

bind cic5_decimator cic5_decimator_chk #(
  .RATIO(RATIO), .COEF_W(COEF_W), .OUT_W(OUT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .gain_coef (gain_coef),
  .out_valid (out_valid),
  .out_i     (out_i),
  .out_q     (out_q)
);

// File: tb/tb_cic5_decimator.sv
`timescale 1ns/1ps
module tb_cic5_decimator;

  localparam int RATIO  = 18;
  localparam int STAGES = 5;
  localparam int NH     = STAGES * (RATIO - 1) + 1;
  localparam int MAXS   = 4096;

  logic               clk = 1'b0;
  logic               rst;
  logic               in_valid;
  logic signed [15:0] in_i, in_q;
  logic [17:0]        gain_coef;
  logic               out_valid;
  logic signed [15:0] out_i, out_q;

  always #4 clk = ~clk;   // 125 MHz

  cic5_decimator dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .gain_coef(gain_coef), .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  int     n_checks = 0;
  int     n_errors = 0;
  int     n_in     = 0;
  int     n_out    = 0;
  string  tag      = "R3";
  longint h  [NH];
  longint xi [MAXS];
  longint xq [MAXS];
  longint exp_i [$];
  longint exp_q [$];
  string  exp_t [$];

  task automatic check(input string t, input longint act, input longint expv);
    n_checks++;
    if (act != expv) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", t, act, expv);
    end
  endtask

  // Expected output from the requirements: convolution, shift, multiply, clip.
  function automatic longint model(input int last, input bit use_q);
    longint acc, g, p, r;
    acc = 0;
    for (int k = 0; k < NH; k++)
      if (last - k >= 0) acc += h[k] * (use_q ? xq[last-k] : xi[last-k]);
    g = acc >>> 20;
    p = g * longint'(gain_coef);
    r = p >>> 16;
    if (r > 32767)  r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  task automatic put(input int vi, input int vq);
    in_i = 16'(vi); in_q = 16'(vq); in_valid = 1'b1;
    xi[n_in] = longint'(in_i);
    xq[n_in] = longint'(in_q);
    if ((n_in + 1) % RATIO == 0) begin
      exp_i.push_back(model(n_in, 1'b0));
      exp_q.push_back(model(n_in, 1'b1));
      exp_t.push_back(tag);
    end
    n_in++;
    @(posedge clk); #1;
    in_valid = 1'b0;
    in_i = 16'($urandom);   // garbage while idle (R6)
    in_q = 16'($urandom);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      in_i = 16'($urandom); in_q = 16'($urandom);
      @(posedge clk); #1;
    end
  endtask

  function automatic int rnd(input int span);
    return int'($urandom_range(2 * span)) - span;
  endfunction

  // Scoreboard monitor.
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      n_out++;
      if (exp_i.size() == 0) begin
        check("R2 unexpected output", n_out, 0);
      end else begin
        string  t;
        longint ei, eq;
        t  = exp_t.pop_front();
        ei = exp_i.pop_front();
        eq = exp_q.pop_front();
        check({t, " out_i"}, longint'(out_i), ei);
        check({t, " out_q"}, longint'(out_q), eq);
      end
    end
  end

  initial begin
    #1600000;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < NH; k++) h[k] = (k < RATIO) ? 1 : 0;
    for (int s = 1; s < STAGES; s++) begin
      longint t [NH];
      for (int k = 0; k < NH; k++) begin
        t[k] = 0;
        for (int j = 0; j < RATIO; j++) if (k - j >= 0) t[k] += h[k-j];
      end
      for (int k = 0; k < NH; k++) h[k] = t[k];
    end

    rst = 1'b1; in_valid = 1'b0; in_i = '0; in_q = '0; gain_coef = 18'd65536;
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check("R1 out_valid after reset", longint'(out_valid), 0);
    check("R1 out_i after reset", longint'(out_i), 0);
    check("R1 out_q after reset", longint'(out_q), 0);
    #1;

    // R2 and R3: DC input, unity coefficient
    tag = "R3";
    for (int k = 0; k < RATIO - 1; k++) put(100, -50);
    idle(20);
    check("R2 no output after 17 inputs", n_out, 0);
    put(100, -50);
    idle(20);
    check("R2 one output after 18 inputs", n_out, 1);
    for (int k = 0; k < RATIO * 5; k++) put(100, -50);
    idle(20);

    // R6 and R7: random data with gaps, independent rails
    tag = "R6 R7";
    for (int k = 0; k < RATIO * 8; k++) begin
      put(rnd(20000), rnd(9000));
      idle(int'($urandom_range(3)));
    end
    idle(20);

    // R4: near-unity normalising coefficient
    gain_coef = 18'd36372;
    tag = "R4";
    for (int k = 0; k < RATIO * 6; k++) put(rnd(30000), rnd(30000));
    idle(20);

    // R5: large gain clips both ways
    gain_coef = 18'h3FFFF;
    tag = "R5";
    for (int k = 0; k < RATIO * 8; k++) put(30000, -30000);
    idle(20);
    check("R5 positive clip", longint'(out_i), 32767);
    check("R5 negative clip", longint'(out_q), -32768);

    // R4: zero coefficient
    gain_coef = 18'd0;
    tag = "R4 zero";
    for (int k = 0; k < RATIO * 4; k++) put(rnd(32000), rnd(32000));
    idle(20);

    // R8: long full-scale run, integrators wrap
    gain_coef = 18'd32768;
    tag = "R8";
    for (int k = 0; k < RATIO * 60; k++) put(32767, -32768);
    idle(20);
    check("R8 steady positive", longint'(out_i), 29523);
    check("R8 steady negative", longint'(out_q), -29525);

    idle(30);
    check("R2 pending outputs", exp_i.size(), 0);
    check("R2 output count", n_out, n_in / RATIO);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule